// File: doc/BRIEF.md
# Staged PLL Setting Register Bank

This block is a small memory-mapped register bank that owns the settings of a clock PLL. Software writes the desired enable and connect bits and the multiplier and pre-divider fields into two holding registers. Those writes do not reach the PLL. The live settings sit in a separate set of shadow registers. A two-word unlock sequence written to a write-only feed register copies both holding registers into the shadow set in one step.

A read-only status word reports the shadow values together with the lock indication from the PLL. Software can therefore tell the pending configuration from the one that is actually in force. The connect output is qualified by the shadow enable bit, the shadow connect bit and the lock input, so the system clock is taken from the PLL only once the PLL has locked.

The bus is a plain single-cycle 32-bit register port. It carries a byte address, a write strobe, write data and combinational read data. There is no read strobe, so only bus writes count as accesses for the unlock sequence.

Top module: `pll_cfg_bank`

## Requirements
- R1: After an active-low reset, all outputs are 0 and the control, configuration and status words read as 0.
- R2: The control word (offset 0x80) holds enable in bit 0 and connect in bit 1. The configuration word (offset 0x84) holds the multiplier in bits [14:0] and the pre-divider in bits [23:16]. Reads return the held values with all other bits 0.
- R3: Writes to the control or configuration word change neither the PLL outputs nor the status word until a valid feed completes.
- R4: A valid feed is a bus write of 0x000000AA to the feed word (offset 0x8C), with the next write to the bank being 0x00000055 to the feed word. It copies both holding words into the shadow set, and the outputs show the new values in the cycle after the 0x55 write.
- R5: Any other write to the bank between the 0xAA and the 0x55 aborts the sequence. A 0x55 not directly preceded by an 0xAA commits nothing. A repeated 0xAA keeps the sequence armed.
- R6: The status word (offset 0x88) carries the shadow multiplier in [14:0], the shadow pre-divider in [23:16], the shadow enable in bit 24, the shadow connect in bit 25 and the lock input in bit 26. Every other bit reads 0.
- R7: The connect output is 1 only when the shadow enable, the shadow connect and the lock input are all 1.
- R8: Reads of the feed word return 0, and writes to the status word have no effect.
- R9: Writes to addresses outside the four bank words change nothing and do not disturb a feed in progress.
- R10: The enable, multiplier and pre-divider outputs equal the shadow values, whatever the state of the lock input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pll_lock_i | input | 1 | Lock indication from the PLL |
| pll_en_o | output | 1 | Live PLL enable |
| pll_conn_o | output | 1 | Qualified clock-connect request |
| pll_msel_o | output | 15 | Live multiplier select |
| pll_nsel_o | output | 8 | Live pre-divider select |

## Verification
The bench builds the block with its default parameters: 15-bit multiplier, 8-bit pre-divider, 8-bit address and bank base 0x80. These widths let it write all-ones patterns that fill each field, so a misplaced status bit or a truncated field shows up directly. The default base also places out-of-bank addresses such as 0x7C and 0x90 next to the bank words, which exercises decode at its edges. The directed sequences cover the ordering corner cases of the unlock: an interleaved write, a lone second key, a repeated first key, and an out-of-bank write in the middle.

// File: rtl/pll_cfg_pkg.sv
// Package: shared constants for the staged PLL setting bank.
// Assumes a 32-bit data bus; the field positions are fixed by the status layout.
package pll_cfg_pkg;
    localparam int unsigned DATA_W        = 32;
    localparam logic [31:0] FEED_KEY_1    = 32'h0000_00AA;
    localparam logic [31:0] FEED_KEY_2    = 32'h0000_0055;
    localparam int unsigned CTRL_EN_BIT   = 0;
    localparam int unsigned CTRL_CONN_BIT = 1;
    localparam int unsigned NSEL_LSB      = 16;
    localparam int unsigned STAT_EN_BIT   = 24;
    localparam int unsigned STAT_CONN_BIT = 25;
    localparam int unsigned STAT_LOCK_BIT = 26;

    // Decoded target of one bus access.
    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_CTRL = 3'd1,
        SEL_CFG  = 3'd2,
        SEL_STAT = 3'd3,
        SEL_FEED = 3'd4
    } bank_sel_e;
endpackage

// File: rtl/pll_feed_seq.sv
// Module: pll_feed_seq
// Tracks the two-key unlock sequence. It arms on the first key written to the
// feed word and fires a one-cycle commit on the second key when armed. Any other
// bank write disarms it. Assumes at most one write per cycle and that
// out-of-bank writes are never presented as bank writes.
module pll_feed_seq
    import pll_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_feed,
    input  logic              wr_other,
    input  logic [DATA_W-1:0] wdata,
    output logic              commit
);
    logic armed_q;
    logic key1_hit;
    logic key2_hit;

    // Compare the write data against both keys.
    always_comb begin
        key1_hit = wr_feed && (wdata == FEED_KEY_1);
        key2_hit = wr_feed && (wdata == FEED_KEY_2);
        commit   = key2_hit && armed_q;
    end

    // Arm on key 1; every other bank write, key 2 included, clears the arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (key1_hit) begin
            armed_q <= 1'b1;
        end else if (wr_feed || wr_other) begin
            armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/pll_reg_store.sv
// Module: pll_reg_store
// Holds the holding registers written by software and the shadow registers that
// drive the PLL. Shadows load from the holding values only on commit.
// Assumes that commit and the holding-register writes never occur in the same cycle.
module pll_reg_store #(
    parameter int unsigned MSEL_W = 15,
    parameter int unsigned NSEL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_cfg,
    input  logic              wd_en,
    input  logic              wd_conn,
    input  logic [MSEL_W-1:0] wd_msel,
    input  logic [NSEL_W-1:0] wd_nsel,
    input  logic              commit,
    output logic              hold_en,
    output logic              hold_conn,
    output logic [MSEL_W-1:0] hold_msel,
    output logic [NSEL_W-1:0] hold_nsel,
    output logic              sh_en,
    output logic              sh_conn,
    output logic [MSEL_W-1:0] sh_msel,
    output logic [NSEL_W-1:0] sh_nsel
);
    // Holding control bits, written directly from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_en   <= 1'b0;
            hold_conn <= 1'b0;
        end else if (wr_ctrl) begin
            hold_en   <= wd_en;
            hold_conn <= wd_conn;
        end
    end

    // Holding configuration fields, written directly from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_msel <= '0;
            hold_nsel <= '0;
        end else if (wr_cfg) begin
            hold_msel <= wd_msel;
            hold_nsel <= wd_nsel;
        end
    end

    // Shadow set, loaded as one unit from the holding registers on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_en   <= 1'b0;
            sh_conn <= 1'b0;
            sh_msel <= '0;
            sh_nsel <= '0;
        end else if (commit) begin
            sh_en   <= hold_en;
            sh_conn <= hold_conn;
            sh_msel <= hold_msel;
            sh_nsel <= hold_nsel;
        end
    end
endmodule

// File: rtl/pll_rd_mux.sv
// Module: pll_rd_mux
// Combinational read-data assembly. Control and configuration return the holding
// values and status returns the shadow values plus lock. Feed and unmapped
// addresses return zero. Assumes field widths that fit the fixed layout.
module pll_rd_mux
    import pll_cfg_pkg::*;
#(
    parameter int unsigned MSEL_W = 15,
    parameter int unsigned NSEL_W = 8
) (
    input  bank_sel_e         sel,
    input  logic              hold_en,
    input  logic              hold_conn,
    input  logic [MSEL_W-1:0] hold_msel,
    input  logic [NSEL_W-1:0] hold_nsel,
    input  logic              sh_en,
    input  logic              sh_conn,
    input  logic [MSEL_W-1:0] sh_msel,
    input  logic [NSEL_W-1:0] sh_nsel,
    input  logic              lock,
    output logic [DATA_W-1:0] rdata
);
    // Place the fields of the selected word and zero every other bit.
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CTRL: begin
                rdata[CTRL_EN_BIT]   = hold_en;
                rdata[CTRL_CONN_BIT] = hold_conn;
            end
            SEL_CFG: begin
                rdata[MSEL_W-1:0]        = hold_msel;
                rdata[NSEL_LSB +: NSEL_W] = hold_nsel;
            end
            SEL_STAT: begin
                rdata[MSEL_W-1:0]        = sh_msel;
                rdata[NSEL_LSB +: NSEL_W] = sh_nsel;
                rdata[STAT_EN_BIT]       = sh_en;
                rdata[STAT_CONN_BIT]     = sh_conn;
                rdata[STAT_LOCK_BIT]     = lock;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/pll_cfg_bank.sv
// Module: pll_cfg_bank (top)
// Register bank for the PLL settings: holding words, a keyed feed that commits
// them into the live shadows, and a status word of live values plus lock.
// Assumes single-cycle bus writes and word-aligned byte addresses.
module pll_cfg_bank
    import pll_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned MSEL_W    = 15,
    parameter int unsigned NSEL_W    = 8,
    parameter logic [7:0]  BANK_BASE = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              pll_lock_i,
    output logic              pll_en_o,
    output logic              pll_conn_o,
    output logic [MSEL_W-1:0] pll_msel_o,
    output logic [NSEL_W-1:0] pll_nsel_o
);
    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(BANK_BASE);
    localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'(BANK_BASE + 8'h04);
    localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(BANK_BASE + 8'h08);
    localparam logic [ADDR_W-1:0] OFS_FEED = ADDR_W'(BANK_BASE + 8'h0C);

    bank_sel_e         sel;
    logic              wr_ctrl, wr_cfg, wr_stat, wr_feed, wr_other;
    logic              commit;
    logic              hold_en, hold_conn, sh_en, sh_conn;
    logic [MSEL_W-1:0] hold_msel, sh_msel;
    logic [NSEL_W-1:0] hold_nsel, sh_nsel;

    // Decode the bus address into one bank word or none.
    always_comb begin
        if (bus_addr == OFS_CTRL)      sel = SEL_CTRL;
        else if (bus_addr == OFS_CFG)  sel = SEL_CFG;
        else if (bus_addr == OFS_STAT) sel = SEL_STAT;
        else if (bus_addr == OFS_FEED) sel = SEL_FEED;
        else                           sel = SEL_NONE;
    end

    // Per-word write strobes; a status write is a bank access that stores nothing.
    always_comb begin
        wr_ctrl  = bus_wr && (sel == SEL_CTRL);
        wr_cfg   = bus_wr && (sel == SEL_CFG);
        wr_stat  = bus_wr && (sel == SEL_STAT);
        wr_feed  = bus_wr && (sel == SEL_FEED);
        wr_other = wr_ctrl || wr_cfg || wr_stat;
    end

    pll_feed_seq u_feed (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_feed  (wr_feed),
        .wr_other (wr_other),
        .wdata    (bus_wdata),
        .commit   (commit)
    );

    pll_reg_store #(
        .MSEL_W (MSEL_W),
        .NSEL_W (NSEL_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wr_cfg    (wr_cfg),
        .wd_en     (bus_wdata[CTRL_EN_BIT]),
        .wd_conn   (bus_wdata[CTRL_CONN_BIT]),
        .wd_msel   (bus_wdata[MSEL_W-1:0]),
        .wd_nsel   (bus_wdata[NSEL_LSB +: NSEL_W]),
        .commit    (commit),
        .hold_en   (hold_en),
        .hold_conn (hold_conn),
        .hold_msel (hold_msel),
        .hold_nsel (hold_nsel),
        .sh_en     (sh_en),
        .sh_conn   (sh_conn),
        .sh_msel   (sh_msel),
        .sh_nsel   (sh_nsel)
    );

    pll_rd_mux #(
        .MSEL_W (MSEL_W),
        .NSEL_W (NSEL_W)
    ) u_rd (
        .sel       (sel),
        .hold_en   (hold_en),
        .hold_conn (hold_conn),
        .hold_msel (hold_msel),
        .hold_nsel (hold_nsel),
        .sh_en     (sh_en),
        .sh_conn   (sh_conn),
        .sh_msel   (sh_msel),
        .sh_nsel   (sh_nsel),
        .lock      (pll_lock_i),
        .rdata     (bus_rdata)
    );

    // Drive the PLL from the shadows; connect waits for enable and lock.
    always_comb begin
        pll_en_o   = sh_en;
        pll_conn_o = sh_en && sh_conn && pll_lock_i;
        pll_msel_o = sh_msel;
        pll_nsel_o = sh_nsel;
    end
endmodule

// File: rtl/pll_cfg_bank_chk.sv
// Module: pll_cfg_bank_chk
// Property checker bound to pll_cfg_bank. It watches the bus and the PLL
// outputs and recomputes the feed keys and offsets from its own parameters.
module pll_cfg_bank_chk #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned MSEL_W    = 15,
    parameter int unsigned NSEL_W    = 8,
    parameter logic [7:0]  BANK_BASE = 8'h80
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              pll_lock_i,
    input logic              pll_en_o,
    input logic              pll_conn_o,
    input logic [MSEL_W-1:0] pll_msel_o,
    input logic [NSEL_W-1:0] pll_nsel_o,
    input logic [MSEL_W-1:0] hold_msel,
    input logic [NSEL_W-1:0] hold_nsel
);
    logic at_feed, at_stat, in_bank, key1_wr, key2_wr;

    // Recompute the bank decode and key writes from the bus alone.
    always_comb begin
        at_feed = (bus_addr == ADDR_W'(BANK_BASE + 8'h0C));
        at_stat = (bus_addr == ADDR_W'(BANK_BASE + 8'h08));
        in_bank = (bus_addr == ADDR_W'(BANK_BASE)) || (bus_addr == ADDR_W'(BANK_BASE + 8'h04))
                  || at_stat || at_feed;
        key1_wr = bus_wr && at_feed && (bus_wdata == 32'h0000_00AA);
        key2_wr = bus_wr && at_feed && (bus_wdata == 32'h0000_0055);
    end

    AST_SHADOW_ONLY_ON_FEED: assert property (@(posedge clk) disable iff (!rst_n)
        !key2_wr |=> $stable({pll_en_o, pll_msel_o, pll_nsel_o})); // R3

    AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (key2_wr && $past(key1_wr)) |=> (pll_msel_o == $past(hold_msel)) && (pll_nsel_o == $past(hold_nsel))); // R4

    AST_NO_COMMIT_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (key2_wr && $past(bus_wr && in_bank && !key1_wr)) |=> $stable({pll_en_o, pll_msel_o, pll_nsel_o})); // R5

    AST_STATUS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        at_stat |-> (bus_rdata[31:27] == 5'd0) && (bus_rdata[15] == 1'b0)); // R6

    AST_CONN_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        pll_conn_o |-> (pll_en_o && pll_lock_i)); // R7

    AST_FEED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        at_feed |-> (bus_rdata == 32'd0)); // R8
endmodule

bind pll_cfg_bank pll_cfg_bank_chk #(
    .ADDR_W    (ADDR_W),
    .MSEL_W    (MSEL_W),
    .NSEL_W    (NSEL_W),
    .BANK_BASE (BANK_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pll_lock_i (pll_lock_i),
    .pll_en_o   (pll_en_o),
    .pll_conn_o (pll_conn_o),
    .pll_msel_o (pll_msel_o),
    .pll_nsel_o (pll_nsel_o),
    .hold_msel  (hold_msel),
    .hold_nsel  (hold_nsel)
);

// File: tb/pll_cfg_bank_tb.sv
// Directed bench for pll_cfg_bank: one task per scenario, each checking its own results.
module pll_cfg_bank_tb;
    localparam logic [7:0] A_CTRL = 8'h80;
    localparam logic [7:0] A_CFG  = 8'h84;
    localparam logic [7:0] A_STAT = 8'h88;
    localparam logic [7:0] A_FEED = 8'h8C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        pll_lock_i = 1'b0;
    logic        pll_en_o, pll_conn_o;
    logic [14:0] pll_msel_o;
    logic [7:0]  pll_nsel_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pll_cfg_bank u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pll_lock_i (pll_lock_i),
        .pll_en_o   (pll_en_o),
        .pll_conn_o (pll_conn_o),
        .pll_msel_o (pll_msel_o),
        .pll_nsel_o (pll_nsel_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 32'd0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = 8'h00;
    endtask

    task automatic feed();
        wr(A_FEED, 32'hAA);
        wr(A_FEED, 32'h55);
    endtask

    function automatic logic [31:0] outs();
        return {6'd0, pll_conn_o, pll_en_o, pll_nsel_o, 1'b0, pll_msel_o};
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 outputs", outs(), 32'd0);
        rd(A_CTRL, d); chk("R1 ctrl", d, 0);
        rd(A_CFG, d);  chk("R1 cfg", d, 0);
        rd(A_STAT, d); chk("R1 status", d, 0);
    endtask

    task automatic t_hold_readback();
        logic [31:0] d;
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, d); chk("R2 ctrl readback", d, 32'h3);
        wr(A_CFG, 32'hFFFF_FFFF);
        rd(A_CFG, d);  chk("R2 cfg readback", d, 32'h00FF_7FFF);
        chk("R3 outputs untouched", outs(), 32'd0);
        rd(A_STAT, d); chk("R3 status untouched", d, 32'd0);
    endtask

    task automatic t_commit();
        logic [31:0] d;
        pll_lock_i = 1'b0;
        feed();
        chk("R4 outputs after feed", outs(), {6'd0, 1'b0, 1'b1, 8'hFF, 1'b0, 15'h7FFF});
        chk("R10 en without lock", {31'd0, pll_en_o}, 1);
        rd(A_STAT, d); chk("R6 status no lock", d, 32'h03FF_7FFF);
        pll_lock_i = 1'b1;
        #1 chk("R7 conn with lock", {31'd0, pll_conn_o}, 1);
        rd(A_STAT, d); chk("R6 status lock", d, 32'h07FF_7FFF);
        pll_lock_i = 1'b0;
        #1 chk("R7 conn drops with lock", {31'd0, pll_conn_o}, 0);
        pll_lock_i = 1'b1;
    endtask

    task automatic t_aborts();
        logic [31:0] d;
        wr(A_CFG, 32'h0012_0345);
        wr(A_FEED, 32'hAA); wr(A_CTRL, 32'h1); wr(A_FEED, 32'h55);
        chk("R5 interleaved write aborts", {17'd0, pll_msel_o}, 32'h7FFF);
        wr(A_FEED, 32'h55);
        chk("R5 lone second key", {24'd0, pll_nsel_o}, 32'hFF);
        wr(A_FEED, 32'hAA); wr(A_STAT, 32'hFFFF_FFFF); wr(A_FEED, 32'h55);
        chk("R8 status write aborts, no commit", {17'd0, pll_msel_o}, 32'h7FFF);
        wr(A_FEED, 32'hAA); wr(A_FEED, 32'h12); wr(A_FEED, 32'h55);
        chk("R5 wrong key aborts", {17'd0, pll_msel_o}, 32'h7FFF);
        wr(A_FEED, 32'hAA); wr(A_FEED, 32'hAA); wr(A_FEED, 32'h55);
        chk("R5 repeated first key commits", outs(), {6'd0, 1'b0, 1'b1, 8'h12, 1'b0, 15'h0345});
        chk("R7 conn low when connect clear", {31'd0, pll_conn_o}, 0);
        rd(A_FEED, d); chk("R8 feed reads zero", d, 0);
    endtask

    task automatic t_outside();
        logic [31:0] d;
        wr(A_CTRL, 32'h2);
        wr(A_CFG, 32'h0007_0009);
        wr(A_FEED, 32'hAA); wr(8'h90, 32'h55); wr(8'h7C, 32'hFFFF); wr(A_FEED, 32'h55);
        chk("R9 out-of-bank keeps sequence", outs(), {6'd0, 1'b0, 1'b0, 8'h07, 1'b0, 15'h0009});
        rd(8'h90, d); chk("R9 unmapped reads zero", d, 0);
        rd(A_STAT, d); chk("R6 status connect only", d, 32'h0607_0009);
        chk("R7 conn low when enable clear", {31'd0, pll_conn_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hold_readback();
        t_commit();
        t_aborts();
        t_outside();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule